// File: doc/BRIEF.md
# Double-Buffered Serial Port

This block is a byte-wide asynchronous serial port seen by software as two 32-bit registers. Characters are sent through a two-stage transmit path: a one-byte holding register sits in front of the shift register that drives the line. Software can therefore queue the next character while the current one is still leaving the pin, and a separate flag for each stage shows where the queue stands. The receive side deserializes one character at a time into a single data register. It flags a character that arrives before the previous one was collected.

The serial format is one start bit, eight data bits sent least significant bit first, and one stop bit, with no parity. Bit timing comes from an external baud tick that runs at sixteen times the bit rate. The receiver uses the same tick to oversample the line. A one-cycle interrupt request pulse marks every finished transmit character and every accepted receive character, so that an interrupt controller can latch it on a single input line.

Top module: `dbuf_uart`

## Requirements
- R1: After reset the status register reads 0x00000006 (bit 1 shift-empty and bit 2 holding-empty set; bit 0 data-ready and bit 4 overrun clear), the serial output is high and the interrupt request is low.
- R2: A write to the data register while shift-empty is set loads the byte into the shift register, clears shift-empty and starts a frame on the serial output.
- R3: A write to the data register while shift-empty is clear stores the byte in the holding register and clears holding-empty.
- R4: When a frame ends and holding-empty is set, shift-empty becomes set. When holding-empty is clear, the held byte starts the next frame with no idle gap and holding-empty becomes set.
- R5: Each frame is a low start bit, eight data bits least significant bit first, and a high stop bit. Each bit lasts 16 baud ticks, and the output is high whenever no frame is in progress.
- R6: The receiver samples the synchronized input on every baud tick. It confirms a start bit 8 ticks after first seeing the line low, then samples each later bit 16 ticks apart. A character with a high stop bit is written to the data register and sets data-ready.
- R7: A character that is accepted while data-ready is already set sets overrun (bit 4). Overrun stays set until a status write clears it.
- R8: A read of the data register returns the byte in bits 7:0 and clears data-ready, unless a character is accepted in the same cycle.
- R9: Any write to the status register clears bits 1, 2 and 4 and leaves data-ready unchanged. After such a write while idle, a data write lands in the holding register and no frame starts.
- R10: A character whose stop bit samples low is discarded. Data-ready, the data register and the interrupt request are unchanged.
- R11: The interrupt request is high for exactly the one cycle after each frame end or accepted receive character, and low otherwise.
- R12: The data register is at byte offset 0x70 and the status register at 0x74. The read result appears on the read-data port in the cycle after the read. Other offsets read as zero, and writes to them have no effect.
- R13: A low pulse on the input that is high again at the start-confirmation sample is ignored, and the receiver returns to waiting for a start bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_sel | input | 1 | Register access strobe, one cycle per access |
| bus_wr | input | 1 | 1 = write access, 0 = read access |
| bus_addr | input | 8 | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid in the cycle after a read |
| baud_tick | input | 1 | One-cycle strobe at 16 times the bit rate |
| txd | output | 1 | Serial output |
| rxd | input | 1 | Serial input, asynchronous |
| irq | output | 1 | Interrupt request pulse |

## Verification
Every cycle, the assertions check the local flag rules. They cover the placement of a written byte (shift register or holding register), the set-on-handoff of holding-empty, the mutual exclusion of shift-empty and an active frame, the idle-high line, the data-ready and overrun updates on receive, read and status write, and the one-cycle interrupt pulse. What only the bench scenarios can show is the frame content and timing on the pin: bit order, exact 16-tick bit length, back-to-back frames, mid-bit sampling of a received byte, and rejection of glitches and bad stop bits. The bench shows these by comparing pin values and read results, cycle by cycle, with an independent behavioural model.

// File: rtl/dbuf_uart_pkg.sv
package dbuf_uart_pkg;

  // status register bit positions (software depends on these)
  localparam int unsigned ST_DR  = 0;
  localparam int unsigned ST_SRE = 1;
  localparam int unsigned ST_HRE = 2;
  localparam int unsigned ST_OVR = 4;

  // assemble the status word from the four flags
  function automatic logic [31:0] pack_status(input logic dr, input logic sre,
                                              input logic hre, input logic ovr);
    logic [31:0] s;
    s         = '0;
    s[ST_DR]  = dr;
    s[ST_SRE] = sre;
    s[ST_HRE] = hre;
    s[ST_OVR] = ovr;
    return s;
  endfunction

endpackage

// File: rtl/dbuf_uart_tx.sv
module dbuf_uart_tx #(
  parameter int unsigned DBITS = 8,
  parameter int unsigned OVS   = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             load,
  input  logic [DBITS-1:0] din,
  input  logic             clr,
  output logic             txd,
  output logic             sre,
  output logic             hre,
  output logic             fin,
  output logic             busy
);
  localparam int unsigned FRAME = DBITS + 2;
  localparam int unsigned CW    = $clog2(OVS);
  localparam int unsigned BW    = $clog2(FRAME);

  // stop bit high, data, start bit low; shifted out from bit 0
  function automatic logic [FRAME-1:0] make_frame(input logic [DBITS-1:0] d);
    return {1'b1, d, 1'b0};
  endfunction

  logic [FRAME-1:0] shreg;
  logic [CW-1:0]    tcnt;
  logic [BW-1:0]    bcnt;
  logic [DBITS-1:0] hold;
  logic             active;

  logic bit_end, sre_a, hre_a, to_shift, to_hold, sre_n, hre_n;

  assign bit_end  = tick & active & (tcnt == CW'(OVS - 1));
  assign fin      = bit_end & (bcnt == BW'(FRAME - 1));
  // flag view after a frame end in this cycle; a write sees this view
  assign sre_a    = sre | (fin & hre);
  assign hre_a    = hre | fin;
  assign to_shift = load & sre_a;
  assign to_hold  = load & ~sre_a;

  always_comb begin
    sre_n = sre_a;
    hre_n = hre_a;
    if (to_shift) sre_n = 1'b0;
    if (to_hold)  hre_n = 1'b0;
    if (clr) begin
      sre_n = 1'b0;
      hre_n = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shreg  <= '1;
      tcnt   <= '0;
      bcnt   <= '0;
      hold   <= '0;
      active <= 1'b0;
      sre    <= 1'b1;
      hre    <= 1'b1;
    end else begin
      sre <= sre_n;
      hre <= hre_n;
      if (tick && active) begin
        if (bit_end) begin
          tcnt  <= '0;
          shreg <= {1'b1, shreg[FRAME-1:1]};
          bcnt  <= bcnt + 1'b1;
        end else begin
          tcnt <= tcnt + 1'b1;
        end
      end
      if (fin) begin
        if (hre) begin
          active <= 1'b0;
        end else begin
          shreg <= make_frame(hold);
          bcnt  <= '0;
        end
      end
      if (to_shift) begin
        shreg  <= make_frame(din);
        active <= 1'b1;
        tcnt   <= '0;
        bcnt   <= '0;
      end
      if (to_hold) hold <= din;
    end
  end

  assign txd  = ~active | shreg[0];
  assign busy = active;

endmodule

// File: rtl/dbuf_uart_rx.sv
module dbuf_uart_rx #(
  parameter int unsigned DBITS = 8,
  parameter int unsigned OVS   = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             rxd,
  output logic             done,
  output logic [DBITS-1:0] dout
);
  localparam int unsigned CW   = $clog2(OVS);
  localparam int unsigned MID  = OVS / 2 - 1;
  localparam int unsigned LAST = DBITS + 1;
  localparam int unsigned IW   = $clog2(DBITS + 2);

  logic             s1, s2;
  logic             busy;
  logic [CW-1:0]    tcnt;
  logic [IW-1:0]    idx;
  logic [DBITS-1:0] shreg;

  logic sample, start_bad, stop_pt;

  assign sample    = tick & busy & (tcnt == CW'(MID));
  assign start_bad = sample & (idx == '0) & s2;
  assign stop_pt   = sample & (idx == IW'(LAST));
  assign done      = stop_pt & s2;
  assign dout      = shreg;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1    <= 1'b1;
      s2    <= 1'b1;
      busy  <= 1'b0;
      tcnt  <= '0;
      idx   <= '0;
      shreg <= '0;
    end else begin
      s1 <= rxd;
      s2 <= s1;
      if (tick) begin
        if (!busy) begin
          if (!s2) begin
            busy <= 1'b1;
            tcnt <= '0;
            idx  <= '0;
          end
        end else begin
          tcnt <= tcnt + 1'b1;
          if (sample) begin
            idx <= idx + 1'b1;
            if (start_bad || stop_pt) busy <= 1'b0;
            else if (idx != '0) shreg <= {s2, shreg[DBITS-1:1]};
          end
        end
      end
    end
  end

endmodule

// File: rtl/dbuf_uart.sv
module dbuf_uart
  import dbuf_uart_pkg::*;
#(
  parameter int unsigned ADDR_W   = 8,
  parameter int unsigned BUS_W    = 32,
  parameter int unsigned DBITS    = 8,
  parameter int unsigned OVS      = 16,
  parameter logic [7:0]  DATA_OFS = 8'h70,
  parameter logic [7:0]  STAT_OFS = 8'h74
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [BUS_W-1:0]  bus_wdata,
  output logic [BUS_W-1:0]  bus_rdata,
  input  logic              baud_tick,
  output logic              txd,
  input  logic              rxd,
  output logic              irq
);
  // named events, also watched by the bound checker
  logic data_wr, data_rd, stat_wr, stat_rd, any_wr, any_rd;
  logic tx_fin, tx_busy, tx_sre, tx_hre;
  logic rx_done;
  logic [DBITS-1:0] rx_byte;
  logic st_dr, st_ovr;
  logic [DBITS-1:0] data_q;
  logic [BUS_W-1:0] rd_val;
  logic [31:0] stat_word;
  logic unused_hi;

  assign any_wr  = bus_sel & bus_wr;
  assign any_rd  = bus_sel & ~bus_wr;
  assign data_wr = any_wr & (bus_addr == ADDR_W'(DATA_OFS));
  assign stat_wr = any_wr & (bus_addr == ADDR_W'(STAT_OFS));
  assign data_rd = any_rd & (bus_addr == ADDR_W'(DATA_OFS));
  assign stat_rd = any_rd & (bus_addr == ADDR_W'(STAT_OFS));
  assign unused_hi = ^bus_wdata[BUS_W-1:DBITS];

  dbuf_uart_tx #(.DBITS(DBITS), .OVS(OVS)) u_tx (
    .clk  (clk),
    .rst_n(rst_n),
    .tick (baud_tick),
    .load (data_wr),
    .din  (bus_wdata[DBITS-1:0]),
    .clr  (stat_wr),
    .txd  (txd),
    .sre  (tx_sre),
    .hre  (tx_hre),
    .fin  (tx_fin),
    .busy (tx_busy)
  );

  dbuf_uart_rx #(.DBITS(DBITS), .OVS(OVS)) u_rx (
    .clk  (clk),
    .rst_n(rst_n),
    .tick (baud_tick),
    .rxd  (rxd),
    .done (rx_done),
    .dout (rx_byte)
  );

  assign stat_word = pack_status(st_dr, tx_sre, tx_hre, st_ovr);

  always_comb begin
    rd_val = '0;
    if (data_rd)      rd_val = BUS_W'(data_q);
    else if (stat_rd) rd_val = BUS_W'(stat_word);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_dr     <= 1'b0;
      st_ovr    <= 1'b0;
      data_q    <= '0;
      bus_rdata <= '0;
      irq       <= 1'b0;
    end else begin
      if (any_rd) bus_rdata <= rd_val;
      st_ovr <= (st_ovr & ~stat_wr) | (rx_done & st_dr & ~data_rd);
      if (rx_done) begin
        st_dr  <= 1'b1;
        data_q <= rx_byte;
      end else if (data_rd) begin
        st_dr <= 1'b0;
      end
      irq <= tx_fin | rx_done;
    end
  end

endmodule

// File: rtl/dbuf_uart_chk.sv
module dbuf_uart_chk (
  input logic clk,
  input logic rst_n,
  input logic data_wr,
  input logic data_rd,
  input logic stat_wr,
  input logic any_wr,
  input logic tx_fin,
  input logic tx_busy,
  input logic rx_done,
  input logic sre,
  input logic hre,
  input logic dr,
  input logic ovr,
  input logic txd,
  input logic irq
);
  // R1: shift-empty is never shown while a frame is on the line
  a_r1_sre_idle: assert property (@(posedge clk) disable iff (!rst_n)
    sre |-> !tx_busy);

  a_r2_direct_load: assert property (@(posedge clk) disable iff (!rst_n)
    (data_wr && sre) |=> (!sre && tx_busy));

  a_r3_to_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (data_wr && !sre && !tx_fin) |=> !hre);

  a_r4_handoff: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_fin && !hre && !any_wr) |=> (tx_busy && hre && !sre));

  a_r4_drain: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_fin && hre && !any_wr) |=> (sre && !tx_busy));

  a_r5_idle_high: assert property (@(posedge clk) disable iff (!rst_n)
    !tx_busy |-> txd);

  a_r6_dr_set: assert property (@(posedge clk) disable iff (!rst_n)
    rx_done |=> dr);

  a_r7_overrun: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_done && dr && !data_rd) |=> ovr);

  a_r7_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (ovr && !stat_wr) |=> ovr);

  a_r8_read_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (data_rd && !rx_done) |=> !dr);

  a_r9_status_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_wr && !rx_done) |=> (!sre && !hre && !ovr && (dr == $past(dr))));

  a_r11_irq_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_fin || rx_done) |=> irq);

  a_r11_irq_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !(tx_fin || rx_done) |=> !irq);

endmodule

bind dbuf_uart dbuf_uart_chk u_chk (
  .clk    (clk),
  .rst_n  (rst_n),
  .data_wr(data_wr),
  .data_rd(data_rd),
  .stat_wr(stat_wr),
  .any_wr (any_wr),
  .tx_fin (tx_fin),
  .tx_busy(tx_busy),
  .rx_done(rx_done),
  .sre    (tx_sre),
  .hre    (tx_hre),
  .dr     (st_dr),
  .ovr    (st_ovr),
  .txd    (txd),
  .irq    (irq)
);

// File: tb/sim_dbuf_uart.sv
`timescale 1ns/1ps
module sim_dbuf_uart;
  localparam logic [7:0] A_DATA = 8'h70;
  localparam logic [7:0] A_STAT = 8'h74;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_sel = 1'b0, bus_wr = 1'b0;
  logic [7:0]  bus_addr = 8'h00;
  logic [31:0] bus_wdata = 32'h0;
  logic [31:0] bus_rdata;
  logic        baud_tick = 1'b0;
  logic        txd;
  logic        rxd = 1'b1;
  logic        irq;

  int n_checks = 0;
  int n_fails  = 0;
  int irq_seen = 0;
  int cyc      = 0;
  int tick_div = 0;
  int tx_q[$];

  always #5 clk = ~clk;

  dbuf_uart u0 (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .baud_tick(baud_tick), .txd(txd), .rxd(rxd), .irq(irq)
  );

  // baud tick: one cycle in four
  always @(negedge clk) begin
    tick_div  = (tick_div + 1) % 4;
    baud_tick = (tick_div == 0);
  end

  // ---------------- behavioural reference model ----------------
  bit m_sre, m_hre, m_dr, m_ovr, m_active, m_irq, m_d1, m_d2;
  int m_data, m_hold, m_frame, m_phase, m_rxcnt, m_rxbyte;
  logic [31:0] m_rdata;

  function automatic int stat_of(bit dr, bit sre, bit hre, bit ovr);
    return (dr ? 1 : 0) + (sre ? 2 : 0) + (hre ? 4 : 0) + (ovr ? 16 : 0);
  endfunction

  task automatic model_reset();
    m_sre = 1; m_hre = 1; m_dr = 0; m_ovr = 0; m_active = 0; m_irq = 0;
    m_d1 = 1; m_d2 = 1; m_data = 0; m_hold = 0; m_frame = 0; m_phase = 0;
    m_rxcnt = -1; m_rxbyte = 0; m_rdata = 0;
  endtask

  task automatic model_step();
    bit rd, drd, srd, dwr, swr, fin, rxdone, line, pre_dr;
    int k, idx;
    rd  = bus_sel && !bus_wr;
    drd = rd && bus_addr == A_DATA;
    srd = rd && bus_addr == A_STAT;
    dwr = bus_sel && bus_wr && bus_addr == A_DATA;
    swr = bus_sel && bus_wr && bus_addr == A_STAT;
    pre_dr = m_dr;
    if (rd) m_rdata = drd ? m_data : (srd ? stat_of(m_dr, m_sre, m_hre, m_ovr) : 0);
    fin = 0;
    if (baud_tick && m_active) begin
      if (m_phase == 159) begin
        fin = 1;
        if (m_hre) begin m_sre = 1; m_active = 0; end
        else begin m_frame = 512 + 2 * m_hold; m_phase = 0; m_hre = 1; end
      end else m_phase++;
    end
    line = m_d2; rxdone = 0;
    if (baud_tick) begin
      if (m_rxcnt < 0) begin
        if (!line) begin m_rxcnt = 0; m_rxbyte = 0; end
      end else begin
        k = m_rxcnt; m_rxcnt = k + 1;
        if (k % 16 == 7) begin
          idx = k / 16;
          if (idx == 0) begin if (line) m_rxcnt = -1; end
          else if (idx <= 8) begin if (line) m_rxbyte |= (1 << (idx - 1)); end
          else begin m_rxcnt = -1; if (line) rxdone = 1; end
        end
      end
    end
    m_d2 = m_d1; m_d1 = rxd;
    if (dwr) begin
      if (m_sre) begin m_frame = 512 + 2 * int'(bus_wdata[7:0]); m_phase = 0; m_active = 1; m_sre = 0; end
      else begin m_hold = int'(bus_wdata[7:0]); m_hre = 0; end
    end
    if (swr) begin m_sre = 0; m_hre = 0; m_ovr = 0; end
    if (rxdone && pre_dr && !drd) m_ovr = 1;
    if (rxdone) begin m_dr = 1; m_data = m_rxbyte; end
    else if (drd) m_dr = 0;
    m_irq = fin || rxdone;
  endtask

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    n_checks++;
    if (!ok) begin
      n_fails++;
      $display("FAIL %s %s: actual=0x%0h expected=0x%0h at %0t", req, what, act, exp, $time);
    end
  endtask

  // per-cycle comparison, sampled 1 ns after the edge
  always @(posedge clk) begin
    bit exp_txd;
    if (!rst_n) model_reset(); else model_step();
    #1;
    exp_txd = m_active ? bit'((m_frame >> (m_phase / 16)) & 1) : 1'b1;
    check(txd === exp_txd, "R5", "txd", txd, exp_txd);
    check(irq === m_irq,   "R11", "irq", irq, m_irq);
    check(bus_rdata === m_rdata, "R12", "rdata", bus_rdata, m_rdata);
    if (irq === 1'b1) irq_seen++;
  end

  // independent serial decoder of the output pin (R5)
  initial begin
    forever begin
      int b;
      @(negedge clk);
      if (rst_n && txd === 1'b0) begin
        b = 0;
        repeat (32) @(negedge clk);
        for (int i = 0; i < 8; i++) begin
          repeat (64) @(negedge clk);
          if (txd) b |= (1 << i);
        end
        repeat (64) @(negedge clk);
        if (txd !== 1'b1) b = -1;
        tx_q.push_back(b);
      end
    end
  end

  // watchdog
  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000) begin
      n_fails++;
      $display("FAIL watchdog (all requirements): actual=%0d expected<100000 cycles", cyc);
      $display("  End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
      $finish;
    end
  end

  // ---------------- bus and line drivers ----------------
  task automatic bus_write(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_sel = 1; bus_wr = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_sel = 0; bus_wr = 0;
  endtask

  task automatic bus_read(input logic [7:0] a, output logic [31:0] v);
    @(negedge clk);
    bus_sel = 1; bus_wr = 0; bus_addr = a;
    @(negedge clk);
    bus_sel = 0;
    v = bus_rdata;
  endtask

  task automatic send_frame(input logic [7:0] d, input bit stop);
    @(negedge clk); rxd = 0;
    repeat (64) @(negedge clk);
    for (int i = 0; i < 8; i++) begin
      rxd = d[i];
      repeat (64) @(negedge clk);
    end
    rxd = stop;
    repeat (64) @(negedge clk);
    rxd = 1;
  endtask

  task automatic expect_reg(input logic [7:0] a, input string req, input int exp);
    logic [31:0] v;
    bus_read(a, v);
    check(v === 32'(exp), req, $sformatf("read 0x%0h", a), v, exp);
  endtask

  initial begin
    int irq0;
    repeat (4) @(negedge clk);
    rst_n = 1;
    repeat (3) @(negedge clk);

    // R1 reset state
    expect_reg(A_STAT, "R1", 32'h6);
    check(txd === 1'b1 && irq === 1'b0, "R1", "idle pins", {txd, irq}, 2'b10);

    // R2 direct load into the shift register
    bus_write(A_DATA, 32'hA5);
    expect_reg(A_STAT, "R2", 32'h4);
    repeat (700) @(negedge clk);
    expect_reg(A_STAT, "R4", 32'h6);

    // R3 holding register, R4 back-to-back handoff
    irq0 = irq_seen;
    bus_write(A_DATA, 32'h3C);
    bus_write(A_DATA, 32'hFFFF_FFC3);
    expect_reg(A_STAT, "R3", 32'h0);
    repeat (800) @(negedge clk);
    expect_reg(A_STAT, "R4", 32'h4);
    repeat (700) @(negedge clk);
    expect_reg(A_STAT, "R4", 32'h6);
    check(irq_seen - irq0 == 2, "R11", "tx pulses", irq_seen - irq0, 2);
    check(tx_q.size() == 3, "R5", "frames seen", tx_q.size(), 3);
    if (tx_q.size() == 3) begin
      check(tx_q[0] == 8'hA5, "R5", "frame 0", tx_q[0], 8'hA5);
      check(tx_q[1] == 8'h3C, "R5", "frame 1", tx_q[1], 8'h3C);
      check(tx_q[2] == 8'hC3, "R5", "frame 2", tx_q[2], 8'hC3);
    end

    // R6 receive, R8 read clears data-ready
    irq0 = irq_seen;
    send_frame(8'h5A, 1);
    repeat (10) @(negedge clk);
    expect_reg(A_STAT, "R6", 32'h7);
    check(irq_seen - irq0 == 1, "R11", "rx pulse", irq_seen - irq0, 1);
    expect_reg(A_DATA, "R8", 32'h5A);
    expect_reg(A_STAT, "R8", 32'h6);

    // R7 overrun
    send_frame(8'h11, 1);
    send_frame(8'h22, 1);
    repeat (10) @(negedge clk);
    expect_reg(A_STAT, "R7", 32'h17);
    expect_reg(A_DATA, "R7", 32'h22);
    expect_reg(A_STAT, "R7", 32'h16);

    // R10 bad stop bit discarded
    irq0 = irq_seen;
    send_frame(8'h99, 0);
    repeat (400) @(negedge clk);
    expect_reg(A_STAT, "R10", 32'h16);
    expect_reg(A_DATA, "R10", 32'h22);
    check(irq_seen == irq0, "R10", "no irq", irq_seen - irq0, 0);

    // R13 short glitch ignored
    @(negedge clk); rxd = 0;
    repeat (12) @(negedge clk); rxd = 1;
    repeat (800) @(negedge clk);
    expect_reg(A_STAT, "R13", 32'h16);
    check(irq_seen == irq0, "R13", "no irq", irq_seen - irq0, 0);

    // R12 decode of other offsets
    expect_reg(8'h78, "R12", 32'h0);
    bus_write(8'h00, 32'h55);
    bus_write(8'h10, 32'hFFFF_FFFF);
    expect_reg(A_STAT, "R12", 32'h16);
    repeat (100) @(negedge clk);
    check(txd === 1'b1, "R12", "txd after stray write", txd, 1);

    // R9 status write clears all but data-ready
    send_frame(8'h81, 1);
    repeat (10) @(negedge clk);
    bus_write(A_STAT, 32'hFFFF_FFFF);
    expect_reg(A_STAT, "R9", 32'h1);
    expect_reg(A_DATA, "R9", 32'h81);
    bus_write(A_DATA, 32'h77);
    repeat (200) @(negedge clk);
    expect_reg(A_STAT, "R9", 32'h0);
    check(txd === 1'b1, "R9", "no frame started", txd, 1);

    $display("  End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
    $finish;
  end

endmodule